// File: doc/BRIEF.md
# Command-Stream Controller ALU

This block is the arithmetic and logic unit of a small command-stream microcontroller. Each cycle it takes an opcode, a first source, a second source and a sixteen-bit immediate, and it returns a 32-bit result and a carry or borrow bit. The second source is either the register value or the immediate, zero-extended. The datapath is combinational. The only state is a one-bit carry flag. That flag links a low-word add or subtract to the high-word add or subtract that follows it, so 64-bit arithmetic takes two instructions.

The compare operation returns a small code chosen so that a single-bit branch test can decide greater-than, greater-or-equal, less-than or less-or-equal. There is also an immediate-move form. It places the immediate at a bit offset given by a separate shift field, so a shift of 16 loads the upper half-word. Register file, decode and writeback are outside the block, and they drive the issue strobe.

Top module: `cp_alu`

## Requirements
- R1: `ADD` (opcode 0) returns src1+b modulo 2^32 with `carry_o` = carry out of bit 31. `SUB` (opcode 2) returns src1-b modulo 2^32 with `carry_o` = 1 exactly when src1 < b, as unsigned values. Here b is the selected second operand.
- R2: When `use_imm_i` is 1, the second operand is `imm_i` zero-extended to 32 bits. Otherwise it is `src2_i`.
- R3: `CMP` (opcode 15) returns 0x00 when src1 > b, 0x2b when src1 == b and 0x1e when src1 < b, comparing unsigned.
- R4: Bit 1 of the `CMP` result is 1 exactly when src1 <= b (unsigned).
- R5: `ADDHI` (opcode 1) returns src1+b+flag. `SUBHI` (opcode 3) returns src1-b-flag. Both report their own carry or borrow on `carry_o`. Here flag is the registered carry flag shown on `flag_o`.
- R6: The bitwise opcodes are `AND`=4, `OR`=5, `XOR`=6 and `NOT`=7. `NOT` returns the bitwise inverse of b and ignores src1.
- R7: The shifts and the rotate use the low 5 bits of b as the amount. `SHL`=8 shifts left, `USHR`=9 shifts right with zero fill, `ISHR`=10 shifts right with sign fill, and `ROT`=11 rotates left.
- R8: `MUL8` (opcode 12) returns the unsigned product of src1[7:0] and b[7:0], zero-extended.
- R9: `MIN` (opcode 13) and `MAX` (opcode 14) return the unsigned smaller and larger of src1 and b.
- R10: `MOVI` (opcode 16) returns the zero-extended `imm_i` shifted left by `imm_shift_i`. Bits shifted past bit 31 are lost, and src1, src2 and `use_imm_i` have no effect.
- R11: Opcodes 17 to 31 return result 0 with `carry_o` 0. Every opcode other than 0 to 3 drives `carry_o` to 0.
- R12: Synchronous active-low reset clears `flag_o`. At a clock edge with `en_i` high and opcode 0 to 3, `flag_o` takes that cycle's `carry_o`. At every other edge `flag_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Issue strobe; the instruction this cycle is executed |
| op_i | input | 5 | Operation code |
| src1_i | input | 32 | First source operand |
| src2_i | input | 32 | Second source register value |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Select immediate as second operand |
| imm_shift_i | input | 5 | Left-shift amount for the immediate move |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Carry or borrow of the current add or subtract |
| flag_o | output | 1 | Registered carry flag used by the high-half operations |

## Verification
The flag assertions assume that reset is held at least one clock and that every input is a known value whenever `en_i` is sampled. The bench sets all inputs at the falling edge, while reset is still asserted, and only then releases reset. The combinational assertions on compare, min and the opcode decode assume `op_i` is stable between edges. The bench changes `op_i` only on falling edges. The stimulus has several parts:
- operand corners: all-ones plus one, zero minus one, and shift amounts of 31 and 32;
- high-half chains after both a carry and a borrow;
- an add issued with `en_i` low, to show the flag holds;
- a run of random vectors that includes undefined opcodes.

// File: rtl/cpalu_pkg.sv
// Package: opcode encoding shared by the ALU and its bench.
// Assumes a 5-bit opcode field; codes 17..31 are unassigned.
package cpalu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDHI = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBHI = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOT   = 5'd7,
        OP_SHL   = 5'd8,
        OP_USHR  = 5'd9,
        OP_ISHR  = 5'd10,
        OP_ROT   = 5'd11,
        OP_MUL8  = 5'd12,
        OP_MIN   = 5'd13,
        OP_MAX   = 5'd14,
        OP_CMP   = 5'd15,
        OP_MOVI  = 5'd16
    } alu_op_e;

    localparam logic [7:0] CMP_GT_CODE = 8'h00;
    localparam logic [7:0] CMP_EQ_CODE = 8'h2b;
    localparam logic [7:0] CMP_LT_CODE = 8'h1e;

    // True for the four operations that produce and latch a carry/borrow.
    function automatic logic is_carry_op(input logic [4:0] op);
        return op inside {OP_ADD, OP_ADDHI, OP_SUB, OP_SUBHI};
    endfunction

endpackage

// File: rtl/cpalu_operand.sv
// Operand stage: selects the second operand and builds the immediate-move value.
// Assumes IW <= DW; the immediate is always zero-extended.
module cpalu_operand #(
    parameter int DW  = 32,
    parameter int IW  = 16,
    localparam int SHW = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  src2_i,
    input  logic [IW-1:0]  imm_i,
    input  logic           use_imm_i,
    input  logic [SHW-1:0] imm_shift_i,
    output logic [DW-1:0]  opb_o,
    output logic [DW-1:0]  movi_o
);

    logic [DW-1:0] imm_ext;

    // Zero-extend the immediate, pick operand B, shift for the move form.
    always_comb begin
        imm_ext = {{(DW-IW){1'b0}}, imm_i};
        opb_o   = use_imm_i ? imm_ext : src2_i;
        movi_o  = imm_ext << imm_shift_i;
    end

    // Immediate operand never carries bits above the immediate width.
    p_imm_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        use_imm_i |-> (opb_o >> IW) == '0);

    // Immediate-move value never holds bits below the shift position.
    p_movi_low_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_shift_i != '0) |-> (movi_o << (DW - int'(imm_shift_i))) == '0);

endmodule

// File: rtl/cpalu_arith.sv
// Arithmetic unit: add/sub with carry chain, min, max and three-way compare.
// Assumes unsigned operands; cin_i is the registered flag from the previous op.
module cpalu_arith
    import cpalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o,
    output logic          hit_o
);

    localparam logic [DW-1:0] GT_W = {{(DW-8){1'b0}}, CMP_GT_CODE};
    localparam logic [DW-1:0] EQ_W = {{(DW-8){1'b0}}, CMP_EQ_CODE};
    localparam logic [DW-1:0] LT_W = {{(DW-8){1'b0}}, CMP_LT_CODE};

    logic          add_cin;
    logic          sub_bin;
    logic [DW:0]   sum_w;
    logic [DW:0]   diff_w;
    logic          a_lt_b;
    logic          a_eq_b;

    // Carry-chained adder and subtractor sharing one flag input.
    always_comb begin
        add_cin = (op_i == OP_ADDHI) && cin_i;
        sub_bin = (op_i == OP_SUBHI) && cin_i;
        sum_w   = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, add_cin};
        diff_w  = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, sub_bin};
        a_lt_b  = a_i < b_i;
        a_eq_b  = a_i == b_i;
    end

    // Select the arithmetic result for the opcode.
    always_comb begin
        res_o  = '0;
        cout_o = 1'b0;
        hit_o  = 1'b1;
        case (op_i)
            OP_ADD, OP_ADDHI: begin res_o = sum_w[DW-1:0];  cout_o = sum_w[DW];  end
            OP_SUB, OP_SUBHI: begin res_o = diff_w[DW-1:0]; cout_o = diff_w[DW]; end
            OP_MIN:  res_o = a_lt_b ? a_i : b_i;
            OP_MAX:  res_o = a_lt_b ? b_i : a_i;
            OP_CMP:  res_o = a_eq_b ? EQ_W : (a_lt_b ? LT_W : GT_W);
            default: hit_o = 1'b0;
        endcase
    end

    // Compare result is always one of the three codes.
    p_cmp_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> (res_o == GT_W || res_o == EQ_W || res_o == LT_W));

    // Bit 1 of the compare code encodes less-or-equal.
    p_cmp_le_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> (res_o[1] == (a_i <= b_i)));

    // Minimum is never larger than either source.
    p_min_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MIN) |-> (res_o <= a_i && res_o <= b_i));

endmodule

// File: rtl/cpalu_logic.sv
// Logic unit: bitwise ops, shifts, rotate and the low-byte multiply.
// Assumes shift amounts come from the low log2(DW) bits of operand B.
module cpalu_logic
    import cpalu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int MULW = 8,
    localparam int SHW = $clog2(DW)
) (
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          hit_o
);

    logic [SHW-1:0]    sh;
    logic [2*DW-1:0]   rot_w;
    logic [2*MULW-1:0] prod;

    // Shift amount, doubled-word rotate and narrow product.
    always_comb begin
        sh    = b_i[SHW-1:0];
        rot_w = {a_i, a_i} << sh;
        prod  = a_i[MULW-1:0] * b_i[MULW-1:0];
    end

    // Select the logic result for the opcode.
    always_comb begin
        res_o = '0;
        hit_o = 1'b1;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~b_i;
            OP_SHL:  res_o = a_i << sh;
            OP_USHR: res_o = a_i >> sh;
            OP_ISHR: res_o = $signed(a_i) >>> sh;
            OP_ROT:  res_o = rot_w[2*DW-1:DW];
            OP_MUL8: res_o = {{(DW-2*MULW){1'b0}}, prod};
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpalu_flag.sv
// Carry flag register: loads on an issued add/sub, holds otherwise.
// Assumes synchronous active-low reset.
module cpalu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic d_i,
    output logic q_o
);

    // Latch the carry of an issued arithmetic op.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (load_i) q_o <= d_i;
    end

    // Flag takes the carry presented at the loading edge.
    p_flag_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(d_i)));

    // Flag is untouched when nothing loads it.
    p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/cp_alu.sv
// Top: combinational ALU for the command-stream controller with a carry flag.
// Assumes decode drives en_i only for instructions that really execute.
module cp_alu
    import cpalu_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IW   = 16,
    parameter int MULW = 8,
    localparam int SHW = $clog2(DW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [4:0]     op_i,
    input  logic [DW-1:0]  src1_i,
    input  logic [DW-1:0]  src2_i,
    input  logic [IW-1:0]  imm_i,
    input  logic           use_imm_i,
    input  logic [SHW-1:0] imm_shift_i,
    output logic [DW-1:0]  result_o,
    output logic           carry_o,
    output logic           flag_o
);

    logic [DW-1:0] opb, movi_val, arith_res, logic_res;
    logic          arith_cout, arith_hit, logic_hit;

    cpalu_operand #(.DW(DW), .IW(IW)) i_operand (
        .clk(clk), .rst_n(rst_n), .src2_i(src2_i), .imm_i(imm_i),
        .use_imm_i(use_imm_i), .imm_shift_i(imm_shift_i),
        .opb_o(opb), .movi_o(movi_val)
    );

    cpalu_arith #(.DW(DW)) i_arith (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(src1_i), .b_i(opb),
        .cin_i(flag_o), .res_o(arith_res), .cout_o(arith_cout), .hit_o(arith_hit)
    );

    cpalu_logic #(.DW(DW), .MULW(MULW)) i_logic (
        .op_i(op_i), .a_i(src1_i), .b_i(opb), .res_o(logic_res), .hit_o(logic_hit)
    );

    cpalu_flag i_flag (
        .clk(clk), .rst_n(rst_n), .load_i(en_i && is_carry_op(op_i)),
        .d_i(carry_o), .q_o(flag_o)
    );

    // Merge the unit results; undefined opcodes give zero.
    always_comb begin
        carry_o = arith_hit && arith_cout;
        if (op_i == OP_MOVI) result_o = movi_val;
        else if (arith_hit)  result_o = arith_res;
        else if (logic_hit)  result_o = logic_res;
        else                 result_o = '0;
    end

    // Unassigned opcodes produce nothing.
    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_MOVI) |-> (result_o == '0 && !carry_o));

    // Carry only ever comes from the four add/sub opcodes.
    p_carry_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> is_carry_op(op_i));

endmodule

// File: tb/test_cp_alu.sv
module test_cp_alu;
    import cpalu_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_i;
    logic [4:0]  op_i;
    logic [31:0] src1_i, src2_i;
    logic [15:0] imm_i;
    logic        use_imm_i;
    logic [4:0]  imm_shift_i;
    logic [31:0] result_o;
    logic        carry_o, flag_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit mflag = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cp_alu i_cp_alu (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .src1_i(src1_i),
        .src2_i(src2_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
        .imm_shift_i(imm_shift_i), .result_o(result_o), .carry_o(carry_o),
        .flag_o(flag_o)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            OP_ADD, OP_SUB:     return "R1";
            OP_ADDHI, OP_SUBHI: return "R5";
            OP_CMP:             return "R3";
            OP_AND, OP_OR, OP_XOR, OP_NOT: return "R6";
            OP_SHL, OP_USHR, OP_ISHR, OP_ROT: return "R7";
            OP_MUL8:            return "R8";
            OP_MIN, OP_MAX:     return "R9";
            OP_MOVI:            return "R10";
            default:            return "R11";
        endcase
    endfunction

    // Behavioural reference: integer arithmetic from the requirements.
    task automatic model(input logic [4:0] op, input longint a, input longint b,
                         input longint imm, input int ish, input bit f,
                         output longint r, output bit c);
        longint m32 = 64'hFFFF_FFFF;
        int s = int'(b % 32);
        c = 1'b0;
        r = 0;
        case (op)
            OP_ADD:   begin r = a + b;      c = r > m32; end
            OP_ADDHI: begin r = a + b + f;  c = r > m32; end
            OP_SUB:   begin r = a - b;      c = r < 0;   end
            OP_SUBHI: begin r = a - b - f;  c = r < 0;   end
            OP_AND:   r = a & b;
            OP_OR:    r = a | b;
            OP_XOR:   r = a ^ b;
            OP_NOT:   r = m32 - b;
            OP_SHL:   r = a * (64'd1 << s);
            OP_USHR:  r = a / (64'd1 << s);
            OP_ISHR:  begin
                r = a / (64'd1 << s);
                if (a >= 64'h8000_0000) r = r + (m32 - (m32 / (64'd1 << s)));
            end
            OP_ROT:   r = (a * (64'd1 << s)) + (a / (64'd1 << (32 - s)));
            OP_MUL8:  r = (a % 256) * (b % 256);
            OP_MIN:   r = (a < b) ? a : b;
            OP_MAX:   r = (a < b) ? b : a;
            OP_CMP:   r = (a == b) ? 'h2b : ((a < b) ? 'h1e : 'h00);
            OP_MOVI:  r = imm * (64'd1 << ish);
            default:  r = 0;
        endcase
        r = r & m32;
    endtask

    task automatic apply(input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] s2, input logic [15:0] imm,
                         input bit ui, input logic [4:0] ish, input bit en);
        longint b, er;
        bit ec;
        op_i = op; src1_i = a; src2_i = s2; imm_i = imm;
        use_imm_i = ui; imm_shift_i = ish; en_i = en;
        #(CLK_P/4);
        b = ui ? longint'(imm) : longint'(s2);
        model(op, longint'(a), b, longint'(imm), int'(ish), mflag, er, ec);
        n_vec++;
        if (longint'(result_o) != er || carry_o != ec) begin
            n_bad++;
            $display("FAIL %s%s op=%0d result=%h carry=%b expected result=%h carry=%b",
                     req_of(op), ui ? "/R2" : "", op, result_o, carry_o,
                     er[31:0], ec);
        end
        if (flag_o != mflag) begin
            n_bad++;
            $display("FAIL R12 flag=%b expected %b", flag_o, mflag);
        end
        if (op == OP_CMP && result_o[1] != (longint'(a) <= b)) begin
            n_bad++;
            $display("FAIL R4 le bit=%b expected %b", result_o[1], longint'(a) <= b);
        end
        @(posedge clk);
        if (en && is_carry_op(op)) mflag = ec;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; en_i = 1'b0; op_i = '0; src1_i = '0; src2_i = '0;
        imm_i = '0; use_imm_i = 1'b0; imm_shift_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (flag_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R12 reset flag=%b expected 0", flag_o);
        end
        rst_n = 1'b1;
        // R1/R5: 64-bit add with carry into the high half.
        apply(OP_ADD,   32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, 1);
        apply(OP_ADDHI, 32'h0000_0005, 32'h2, 16'h0, 0, 0, 1);
        // R1/R5: 64-bit subtract with borrow.
        apply(OP_SUB,   32'h0, 32'h1, 16'h0, 0, 0, 1);
        apply(OP_SUBHI, 32'h10, 32'h3, 16'h0, 0, 0, 1);
        // R12: add issued with en low leaves the flag alone.
        apply(OP_ADD,   32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 0, 0);
        apply(OP_ADDHI, 32'h1, 32'h1, 16'h0, 0, 0, 1);
        // R12: non-arith issued op holds the flag.
        apply(OP_SUB,   32'h1, 32'h2, 16'h0, 0, 0, 1);
        apply(OP_XOR,   32'hF0F0, 32'h0FF0, 16'h0, 0, 0, 1);
        apply(OP_SUBHI, 32'h1, 32'h0, 16'h0, 0, 0, 1);
        // R2: immediate is zero-extended.
        apply(OP_ADD,   32'h1, 32'hFFFF_FFFF, 16'hFFFF, 1, 0, 1);
        // R3/R4: compare greater, equal, less.
        apply(OP_CMP, 32'h9, 32'h8, 16'h0, 0, 0, 1);
        apply(OP_CMP, 32'h8, 32'h8, 16'h0, 0, 0, 1);
        apply(OP_CMP, 32'h7, 32'h8, 16'h0, 0, 0, 1);
        apply(OP_CMP, 32'h8000_0000, 32'h1, 16'h0, 0, 0, 1);
        // R6: NOT ignores src1, takes immediate.
        apply(OP_NOT, 32'h1234_5678, 32'h0, 16'h00FF, 1, 0, 1);
        // R7: shift amounts 31 and 32 (low five bits give 0).
        apply(OP_SHL,  32'h3, 32'd31, 16'h0, 0, 0, 1);
        apply(OP_SHL,  32'h3, 32'd32, 16'h0, 0, 0, 1);
        apply(OP_ISHR, 32'h8000_0010, 32'd4, 16'h0, 0, 0, 1);
        apply(OP_USHR, 32'h8000_0010, 32'd4, 16'h0, 0, 0, 1);
        apply(OP_ROT,  32'h8000_0001, 32'd1, 16'h0, 0, 0, 1);
        // R8: upper bits ignored by the multiply.
        apply(OP_MUL8, 32'hABCD_12FF, 32'h5555_00FF, 16'h0, 0, 0, 1);
        // R9: unsigned min/max.
        apply(OP_MIN, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 1);
        apply(OP_MAX, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 1);
        // R10: upper half-word load and overflow past bit 31.
        apply(OP_MOVI, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 0, 5'd16, 1);
        apply(OP_MOVI, 32'h0, 32'h0, 16'hABCD, 1, 5'd28, 1);
        // R11: undefined opcode.
        apply(5'd20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 0, 0, 1);
        for (int i = 0; i < 3000; i++) begin
            apply(5'($urandom_range(0, 19)), $urandom(), $urandom(),
                  16'($urandom()), 1'($urandom()), 5'($urandom()),
                  1'($urandom()));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule